// File: doc/BRIEF.md
# Receiver Flow-Control Credit Issuer

This block keeps the receive-side credit books for one traffic category of a packetized serial link. It counts what the link partner has spent (each stored packet costs one header credit plus its payload in 16-byte data units) and what the local application has drained from the buffers. From these counts it forms the cumulative credit totals to advertise. Each total is a running value that wraps at its field width: 8 bits for headers, 12 bits for data. The partner does the subtraction against its own spent count, so the block never sends free space directly.

A separate packet builder turns the advertisement into a link packet. The block raises an update request and holds it until the builder acknowledges it. Both totals are captured together on the cycle the request rises and stay frozen while the request is pending. A request is raised for one of two reasons. The first is that the partner may be running out of credits while fresh credits exist. The second is that the maximum refresh interval has run out since the last capture. A zero initial value for a field selects unlimited credit for that field. That field then reads zero at all times and never triggers an update. When both fields are zero, no update is ever requested.

Top module: `fc_credit_issuer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `adv_hdr` equals INIT_HDR_CR, `adv_data` equals INIT_DATA_CR and `upd_req` is 0. A later reset reloads these values and discards all counts.
- R2: One header credit is one stored packet. One data credit is 16 bytes. The captured data total is INIT_DATA_CR plus all data units released before the capture edge, and the header total is INIT_HDR_CR plus all released headers.
- R3: The header total wraps modulo 256 and the data total wraps modulo 4096.
- R4: A captured total is never more than 127 header credits or 2047 data credits ahead of the credits consumed so far. A larger total is clamped to consumed plus that limit.
- R5: A field whose initial value is 0 reads 0 forever and never causes an update. With both fields at 0, `upd_req` never rises.
- R6: If nothing else triggers an update, `upd_req` rises exactly UPDATE_PERIOD clock edges after the previous capture edge, or after reset is released. This happens even when no new credits exist.
- R7: A field counts as starving when its held total minus the credits consumed (mod width) is below its threshold: MAX_PAYLOAD_CR for data and 1 for headers. If a field is starving, has a different total ready, and no request is pending, `upd_req` rises on the next edge. A starving field with nothing new to offer raises no request.
- R8: Once `upd_req` is high it stays high, and both outputs stay stable, until `upd_ack` is sampled high. `upd_req` then drops on that edge.
- R9: Both totals are captured on the same edge. They take the values present just before the edge on which `upd_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlp_stored | input | 1 | One packet was written into the receive buffers this cycle |
| tlp_units | input | PAYLOAD_W | Payload size of that packet in 16-byte units |
| app_release | input | 1 | The application drained buffer space this cycle |
| rel_hdr | input | REL_HDR_W | Number of headers drained |
| rel_units | input | REL_DATA_W | Number of 16-byte data units drained |
| upd_ack | input | 1 | Packet builder accepted the pending update |
| upd_req | output | 1 | Update request, held until acknowledged |
| adv_hdr | output | 8 | Captured cumulative header credit total |
| adv_data | output | 12 | Captured cumulative data credit total |

## Verification
The bench checks the exact release edge of the periodic request, both after reset and after a capture. A timer that restarts on acknowledge instead of on capture misses this by the ack delay. It checks the starvation trigger against a buffer that is exactly one payload short, and checks that no request appears until new credit exists. It also checks that the totals stay frozen while the builder withholds its acknowledge, even when more space is released meanwhile. Long same-size traffic drives both totals past their wrap points. Over-release must clamp to consumed plus 127 or 2047. A design that compares without modular arithmetic, or omits the clamp, ends with the wrong final totals. An instance built with zero initial values must stay silent and read zero throughout.

// File: rtl/fc_credit_pkg.sv
package fc_credit_pkg;

    // Field widths of the advertised totals and their run-ahead limits
    localparam int HDR_W    = 8;
    localparam int DATA_W   = 12;
    localparam int HDR_CAP  = 127;
    localparam int DATA_CAP = 2047;

    typedef logic [HDR_W-1:0]  hdr_cr_t;
    typedef logic [DATA_W-1:0] data_cr_t;

    // One header amount paired with one data amount
    typedef struct packed {
        hdr_cr_t  hdr;
        data_cr_t data;
    } cr_pair_t;

    // Why the scheduler raises a request this cycle
    typedef enum logic [1:0] {
        TRIG_IDLE   = 2'd0,
        TRIG_STARVE = 2'd1,
        TRIG_TIMER  = 2'd2
    } upd_cause_e;

endpackage

// File: rtl/fc_credit_field.sv
module fc_credit_field #(
    parameter int W         = 8,
    parameter int INIT      = 32,
    parameter int CAP       = 127,
    parameter int STARVE_AT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cons_add,
    input  logic [W-1:0] rel_add,
    input  logic         latch,
    output logic [W-1:0] adv_o,
    output logic         fresh_o,
    output logic         starved_o
);

    localparam logic [W-1:0] INIT_V   = W'(INIT);
    localparam logic [W-1:0] CAP_V    = W'(CAP);
    localparam logic [W-1:0] STARVE_V = W'(STARVE_AT);

    generate
        if (INIT == 0) begin : g_unlimited
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, cons_add, rel_add, latch};
            assign adv_o     = '0;
            assign fresh_o   = 1'b0;
            assign starved_o = 1'b0;
        end else begin : g_finite
            logic [W-1:0] cons_q;
            logic [W-1:0] target_q;
            logic [W-1:0] adv_q;
            logic [W-1:0] ahead;
            logic [W-1:0] next_adv;
            logic [W-1:0] avail;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cons_q   <= '0;
                    target_q <= INIT_V;
                    adv_q    <= INIT_V;
                end else begin
                    cons_q   <= cons_q + cons_add;
                    target_q <= target_q + rel_add;
                    if (latch) adv_q <= next_adv;
                end
            end

            always_comb begin
                ahead    = target_q - cons_q;
                next_adv = (ahead > CAP_V) ? (cons_q + CAP_V) : target_q;
                avail    = adv_q - cons_q;
            end

            assign adv_o     = adv_q;
            assign fresh_o   = (next_adv != adv_q);
            assign starved_o = (avail < STARVE_V);

            // R8: the held total moves only on a capture edge
            assert_adv_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !$past(latch) |-> $stable(adv_q));

            // R4: a fresh capture never runs further ahead than the limit
            assert_ahead_cap_R4: assert property (@(posedge clk) disable iff (rst)
                latch |=> ((adv_q - $past(cons_q)) <= CAP_V));
        end
    endgenerate

endmodule

// File: rtl/fc_update_sched.sv
module fc_update_sched
    import fc_credit_pkg::*;
#(
    parameter int PERIOD = 3000,
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic starve,
    input  logic ack,
    output logic fire_o,
    output logic req_o
);

    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    generate
        if (ENABLE) begin : g_sched
            logic [TW-1:0] timer_q;
            logic          req_q;
            upd_cause_e    cause;

            always_comb begin
                cause = TRIG_IDLE;
                if (!rst && !req_q) begin
                    if (starve)                cause = TRIG_STARVE;
                    else if (timer_q == LAST)  cause = TRIG_TIMER;
                end
            end

            assign fire_o = (cause != TRIG_IDLE);
            assign req_o  = req_q;

            // Timer restarts at each capture and saturates while a request waits
            always_ff @(posedge clk) begin
                if (rst) begin
                    timer_q <= '0;
                    req_q   <= 1'b0;
                end else begin
                    if (fire_o)               timer_q <= '0;
                    else if (timer_q != LAST) timer_q <= timer_q + 1'b1;

                    if (fire_o)   req_q <= 1'b1;
                    else if (ack) req_q <= 1'b0;
                end
            end

            // R8: a pending request waits for the acknowledge
            assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
                (req_q && !ack) |=> req_q);

            // R8: an acknowledged request drops on the next edge
            assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst)
                (req_q && ack) |=> !req_q);
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, starve, ack};
            assign fire_o = 1'b0;
            assign req_o  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fc_credit_issuer.sv
module fc_credit_issuer
    import fc_credit_pkg::*;
#(
    parameter int INIT_HDR_CR    = 32,
    parameter int INIT_DATA_CR   = 256,
    parameter int MAX_PAYLOAD_CR = 32,
    parameter int UPDATE_PERIOD  = 3000,
    parameter int PAYLOAD_W      = 8,
    parameter int REL_HDR_W      = 4,
    parameter int REL_DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tlp_stored,
    input  logic [PAYLOAD_W-1:0]  tlp_units,
    input  logic                  app_release,
    input  logic [REL_HDR_W-1:0]  rel_hdr,
    input  logic [REL_DATA_W-1:0] rel_units,
    input  logic                  upd_ack,
    output logic                  upd_req,
    output logic [HDR_W-1:0]      adv_hdr,
    output logic [DATA_W-1:0]     adv_data
);

    localparam bit SCHED_ON = !((INIT_HDR_CR == 0) && (INIT_DATA_CR == 0));

    cr_pair_t consumed;
    cr_pair_t released;
    logic     fire;
    logic     hdr_fresh, hdr_starved;
    logic     data_fresh, data_starved;
    logic     starve;

    always_comb begin
        consumed.hdr  = tlp_stored  ? hdr_cr_t'(1'b1)       : '0;
        consumed.data = tlp_stored  ? data_cr_t'(tlp_units) : '0;
        released.hdr  = app_release ? hdr_cr_t'(rel_hdr)    : '0;
        released.data = app_release ? data_cr_t'(rel_units) : '0;
    end

    fc_credit_field #(
        .W(HDR_W), .INIT(INIT_HDR_CR), .CAP(HDR_CAP), .STARVE_AT(1)
    ) u_hdr (
        .clk(clk), .rst(rst),
        .cons_add(consumed.hdr), .rel_add(released.hdr), .latch(fire),
        .adv_o(adv_hdr), .fresh_o(hdr_fresh), .starved_o(hdr_starved)
    );

    fc_credit_field #(
        .W(DATA_W), .INIT(INIT_DATA_CR), .CAP(DATA_CAP), .STARVE_AT(MAX_PAYLOAD_CR)
    ) u_data (
        .clk(clk), .rst(rst),
        .cons_add(consumed.data), .rel_add(released.data), .latch(fire),
        .adv_o(adv_data), .fresh_o(data_fresh), .starved_o(data_starved)
    );

    assign starve = (hdr_starved && hdr_fresh) || (data_starved && data_fresh);

    fc_update_sched #(
        .PERIOD(UPDATE_PERIOD), .ENABLE(SCHED_ON)
    ) u_sched (
        .clk(clk), .rst(rst), .starve(starve), .ack(upd_ack),
        .fire_o(fire), .req_o(upd_req)
    );

    // R7: a starving field with new credit ready gets a request on the next edge
    assert_starve_req_R7: assert property (@(posedge clk) disable iff (rst)
        (starve && !upd_req) |=> upd_req);

endmodule

// File: tb/fc_credit_issuer_tb.sv
`timescale 1ns/1ps
module fc_credit_issuer_tb;

    localparam int INIT_H = 16;
    localparam int INIT_D = 64;
    localparam int MAXP   = 32;
    localparam int PER    = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tlp_stored = 1'b0;
    logic [7:0]  tlp_units = '0;
    logic        app_release = 1'b0;
    logic [3:0]  rel_hdr = '0;
    logic [7:0]  rel_units = '0;
    logic        upd_ack = 1'b0;
    logic        upd_req, inf_req;
    logic [7:0]  adv_hdr, inf_hdr;
    logic [11:0] adv_data, inf_data;

    int checks = 0;
    int fails  = 0;
    bit auto_ack = 1'b0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    fc_credit_issuer #(
        .INIT_HDR_CR(INIT_H), .INIT_DATA_CR(INIT_D), .MAX_PAYLOAD_CR(MAXP),
        .UPDATE_PERIOD(PER)
    ) u_dut (
        .clk(clk), .rst(rst), .tlp_stored(tlp_stored), .tlp_units(tlp_units),
        .app_release(app_release), .rel_hdr(rel_hdr), .rel_units(rel_units),
        .upd_ack(upd_ack), .upd_req(upd_req), .adv_hdr(adv_hdr), .adv_data(adv_data)
    );

    fc_credit_issuer #(
        .INIT_HDR_CR(0), .INIT_DATA_CR(0), .MAX_PAYLOAD_CR(MAXP),
        .UPDATE_PERIOD(PER)
    ) u_dut_inf (
        .clk(clk), .rst(rst), .tlp_stored(tlp_stored), .tlp_units(tlp_units),
        .app_release(app_release), .rel_hdr(rel_hdr), .rel_units(rel_units),
        .upd_ack(upd_ack), .upd_req(inf_req), .adv_hdr(inf_hdr), .adv_data(inf_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock edge; inputs change and outputs are sampled at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (auto_ack) upd_ack = upd_req;
    endtask

    task automatic clear_inputs();
        tlp_stored = 1'b0; tlp_units = '0;
        app_release = 1'b0; rel_hdr = '0; rel_units = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; auto_ack = 1'b0; upd_ack = 1'b0;
        clear_inputs();
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wait_req(input int limit);
        for (int n = 0; n < limit && !upd_req; n++) tick();
    endtask

    task automatic ack_once();
        upd_ack = 1'b1; tick(); upd_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset hdr", adv_hdr, INIT_H);
        check("R1 reset data", adv_data, INIT_D);
        check("R1 reset req", upd_req, 0);
        check("R5 unlimited reads zero", {inf_hdr, inf_data}, 0);
    endtask

    task automatic t_period();
        int n;
        do_reset();
        n = 0;
        while (!upd_req && n < 4 * PER) begin tick(); n++; end
        check("R6 first period edges", n, PER);
        check("R6 keepalive hdr", adv_hdr, INIT_H);
        check("R6 keepalive data", adv_data, INIT_D);
        ack_once();
        check("R8 drop after ack", upd_req, 0);
        n = 1;
        while (!upd_req && n < 4 * PER) begin tick(); n++; end
        check("R6 period from capture", n, PER);
        ack_once();
    endtask

    task automatic t_starve_handshake();
        do_reset();
        tlp_stored = 1'b1; tlp_units = 8'd40; tick(); clear_inputs();
        tick(); tick(); tick();
        check("R7 starving without new credit stays quiet", upd_req, 0);
        app_release = 1'b1; rel_hdr = 4'd1; rel_units = 8'd8; tick(); clear_inputs();
        check("R7 no request before next edge", upd_req, 0);
        tick();
        check("R7 starvation request", upd_req, 1);
        check("R2 R9 data captured", adv_data, INIT_D + 8);
        check("R2 R9 hdr captured", adv_hdr, INIT_H + 1);
        app_release = 1'b1; rel_units = 8'd4; tick(); clear_inputs();
        for (int k = 0; k < 4; k++) tick();
        check("R8 held without ack", upd_req, 1);
        check("R8 frozen data", adv_data, INIT_D + 8);
        ack_once();
        check("R8 dropped on ack", upd_req, 0);
        check("R8 data after ack", adv_data, INIT_D + 8);
        wait_req(PER + 5);
        check("R2 later release captured", adv_data, INIT_D + 12);
        ack_once();
    endtask

    task automatic t_cap();
        do_reset();
        app_release = 1'b1; rel_hdr = 4'd15; rel_units = 8'd255;
        for (int k = 0; k < 8; k++) tick();
        clear_inputs();
        wait_req(PER + 5);
        check("R4 hdr clamp", adv_hdr, 127);
        check("R4 data clamp", adv_data, 2047);
        ack_once();
        tlp_stored = 1'b1; tlp_units = 8'd20; tick(); clear_inputs();
        wait_req(PER + 5);
        check("R4 hdr clamp follows consumed", adv_hdr, 128);
        check("R4 data clamp follows consumed", adv_data, 2067);
        ack_once();
        do_reset();
        check("R1 reset reloads data", adv_data, INIT_D);
        check("R1 reset reloads hdr", adv_hdr, INIT_H);
    endtask

    task automatic t_wrap();
        bit inf_seen;
        do_reset();
        auto_ack = 1'b1;
        inf_seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tlp_stored = 1'b1; tlp_units = 8'd16;
            app_release = (i > 0); rel_hdr = 4'd1; rel_units = 8'd16;
            tick();
            inf_seen |= inf_req;
        end
        tlp_stored = 1'b0; app_release = 1'b1; rel_hdr = 4'd1; rel_units = 8'd16;
        tick(); clear_inputs();
        tick(); tick(); tick();
        auto_ack = 1'b0; upd_ack = 1'b0;
        wait_req(PER + 5);
        check("R3 data wraps mod 4096", adv_data, (INIT_D + 4800) % 4096);
        check("R3 hdr wraps mod 256", adv_hdr, (INIT_H + 300) % 256);
        check("R5 unlimited never requests", inf_seen, 0);
        check("R5 unlimited totals stay zero", {inf_hdr, inf_data}, 0);
        ack_once();
    endtask

    task automatic t_unlimited_idle();
        bit inf_seen;
        do_reset();
        inf_seen = 1'b0;
        for (int k = 0; k < 3 * PER; k++) begin
            tlp_stored = (k % 3 == 0); tlp_units = 8'd32;
            app_release = (k % 3 == 1); rel_hdr = 4'd1; rel_units = 8'd32;
            tick();
            inf_seen |= inf_req;
            if (upd_req) ack_once();
        end
        clear_inputs();
        check("R5 no request over several periods", inf_seen, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_period();
                t_starve_handshake();
                t_cap();
                t_wrap();
                t_unlimited_idle();
            end
            begin
                #1_500_000;
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule